// File: doc/BRIEF.md
# Byte-Lane Bidirectional Parallel Port with Input Latch

A 32-bit general-purpose parallel port that sits on a processor's local bus. The port is split into four byte lanes, and software sets the direction of each lane on its own. A lane set to output drives the last word written to the data register. A lane set to input presents the external pins through a holding latch. The processor does not see the live pin levels.

The bus is synchronous and takes one cycle per access. A request is `busSel` high for one clock, with `busWe` selecting a write or a read. Five word addresses are decoded: one data register and four direction registers, one per lane. Read data is registered and appears after the clock edge that accepts the read. It then stays unchanged until the next read.

A static mode pin selects what loads the input latch:
- In software mode, every read of the data register captures the pins on the same edge that returns the data.
- In external mode, the falling edge of an active-low readback clock captures the pins. That clock is first passed through a two-flop synchroniser. The captured value is held until the next falling edge.

Top module: `bidir_byte_port`

## Requirements
- R1: After reset every lane is an input (`pinsOe` = 0), `pinsOut` = 0 and `busRdata` = 0.
- R2: Writing direction register k takes effect on the next edge. Lane k's register is at word address 0x400000 + k*0x040000. Bit 0 of the write data sets the direction: 0 makes lane k an output (`pinsOe[k]` = 1), and 1 makes it an input. No other lane changes. `pinsOe` changes only on direction writes.
- R3: Writing the data register (word address 0x300000) loads all 32 bits into `pinsOut` on the next edge, whatever the lane directions are.
- R4: On a data register read, the bits of output lanes return the current output register.
- R5: In software mode (`modeExt` = 0), a data register read returns the input-lane pins as sampled on the edge that accepts the read. The returned value appears on `busRdata` right after that edge.
- R6: In external mode (`modeExt` = 1), input lanes capture the pins on the third clock edge after `extClkN` falls. A data register read returns that held value, and reads do not recapture.
- R7: In external mode, a rising edge of `extClkN` captures nothing.
- R8: Accesses to any other address change no state. Reads of such an address return 0.
- R9: `busRdata` changes only on the edge that accepts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 24 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| modeExt | input | 1 | Static capture select: 0 = on read, 1 = on external clock fall |
| extClkN | input | 1 | Active-low asynchronous readback clock |
| pinsIn | input | 32 | Pin levels seen from outside |
| pinsOut | output | 32 | Output register toward the pads |
| pinsOe | output | 4 | Per-lane drive enable, 1 = drive |

## Verification
A corrupted direction bit shows up at once, on the next edge, as a wrong `pinsOe` bit. It also corrupts the next readback of that lane, because the lane is then served from the wrong source. A bad capture shows up on the first data read after the capture event, as input-lane bytes that do not match the pins present at that event. Two cases expose a latch that follows the pins instead of holding them: changing the pins after an external capture, and applying a rising edge before a read. Both show the error in the very next read.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             wrData;
    logic [LANES-1:0] wrDir;
    logic             rdData;
    logic             rdOther;
    logic             capture;
    logic             readLive;
  } portStrobe_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 24'h300000,
  parameter logic [ADDR_W-1:0] DIR_BASE   = 24'h400000,
  parameter logic [ADDR_W-1:0] DIR_STRIDE = 24'h040000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              modeExt,
  input  logic              extClkN,
  output portStrobe_t       strb
);
  logic [LANES-1:0] dirHit;
  logic dataHit;
  logic syncA, syncB, syncPrev;
  logic extFall;

  assign dataHit = (busAddr == DATA_ADDR);

  for (genvar k = 0; k < LANES; k++) begin : g_dirDecode
    localparam logic [ADDR_W-1:0] LANE_ADDR = DIR_BASE + ADDR_W'(k) * DIR_STRIDE;
    assign dirHit[k] = (busAddr == LANE_ADDR);
  end

  // two-flop synchroniser plus edge history; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      syncA    <= extClkN;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign extFall = syncPrev & ~syncB;

  always_comb begin
    strb          = '0;
    strb.wrData   = busSel & busWe & dataHit;
    strb.wrDir    = {LANES{busSel & busWe}} & dirHit;
    strb.rdData   = busSel & ~busWe & dataHit;
    strb.rdOther  = busSel & ~busWe & ~dataHit;
    strb.readLive = ~modeExt;
    strb.capture  = modeExt ? extFall : strb.rdData;
  end
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] pinsIn,
  output logic [DATA_W-1:0] pinsOut,
  output logic [LANES-1:0]  pinsOe,
  output logic [DATA_W-1:0] busRdata
);
  logic [LANES-1:0]  dirQ;      // 1 = input lane
  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] latchQ;
  logic [DATA_W-1:0] readVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outQ <= '0;
    else if (strb.wrData) outQ <= busWdata;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LO = k * LANE_W;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dirQ[k] <= 1'b1;
      else if (strb.wrDir[k]) dirQ[k] <= busWdata[0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) latchQ[LO +: LANE_W] <= '0;
      else if (strb.capture && dirQ[k]) latchQ[LO +: LANE_W] <= pinsIn[LO +: LANE_W];
    end

    always_comb begin
      if (!dirQ[k])           readVal[LO +: LANE_W] = outQ[LO +: LANE_W];
      else if (strb.readLive) readVal[LO +: LANE_W] = pinsIn[LO +: LANE_W];
      else                    readVal[LO +: LANE_W] = latchQ[LO +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdData) busRdata <= readVal;
    else if (strb.rdOther) busRdata <= '0;
  end

  assign pinsOut = outQ;
  assign pinsOe  = ~dirQ;
endmodule

// File: rtl/bidir_byte_port.sv
module bidir_byte_port
  import bp_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 24'h300000,
  parameter logic [ADDR_W-1:0] DIR_BASE   = 24'h400000,
  parameter logic [ADDR_W-1:0] DIR_STRIDE = 24'h040000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              modeExt,
  input  logic              extClkN,
  input  logic [31:0]       pinsIn,
  output logic [31:0]       pinsOut,
  output logic [3:0]        pinsOe
);
  portStrobe_t strb;

  bp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_BASE(DIR_BASE), .DIR_STRIDE(DIR_STRIDE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .modeExt(modeExt), .extClkN(extClkN), .strb(strb)
  );

  bp_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .pinsIn(pinsIn),
    .pinsOut(pinsOut), .pinsOe(pinsOe), .busRdata(busRdata)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              modeExt,
  input logic [31:0]       pinsIn,
  input logic [31:0]       pinsOut,
  input logic [3:0]        pinsOe
);
  logic dataRd, dataWr, dirWr, otherRd;
  logic [31:0] oeMask;

  assign dataRd  = busSel && !busWe && busAddr == 24'h300000;
  assign dataWr  = busSel && busWe && busAddr == 24'h300000;
  assign otherRd = busSel && !busWe && busAddr != 24'h300000;
  assign dirWr   = busSel && busWe && (busAddr == 24'h400000 || busAddr == 24'h440000 ||
                                       busAddr == 24'h480000 || busAddr == 24'h4C0000);
  assign oeMask  = {{8{pinsOe[3]}}, {8{pinsOe[2]}}, {8{pinsOe[1]}}, {8{pinsOe[0]}}};

  AST_OUT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> pinsOut == $past(busWdata)); // R3
  AST_LANE0_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == 24'h400000) |=> pinsOe[0] == !$past(busWdata[0])); // R2
  AST_LANE3_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == 24'h4C0000) |=> pinsOe[3] == !$past(busWdata[0])); // R2
  AST_OE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !dirWr |=> $stable(pinsOe)); // R2
  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    dataRd |=> (busRdata & oeMask) == ($past(pinsOut) & oeMask)); // R4
  AST_SW_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !modeExt) |=> (busRdata & ~oeMask) == ($past(pinsIn) & ~oeMask)); // R5
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    otherRd |=> busRdata == 32'h0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWe) |=> $stable(busRdata)); // R9
endmodule

bind bidir_byte_port bp_checker #(.ADDR_W(ADDR_W)) i_bpChecker (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .modeExt(modeExt), .pinsIn(pinsIn),
  .pinsOut(pinsOut), .pinsOe(pinsOe)
);

// File: tb/test_bidir_byte_port.sv
module test_bidir_byte_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [23:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic modeExt = 1'b0, extClkN = 1'b1;
  logic [31:0] pinsIn = '0;
  logic [31:0] pinsOut;
  logic [3:0] pinsOe;

  int checks = 0, errors = 0;
  logic [3:0]  expDir;
  logic [31:0] expOut, expLatch, rd;

  always #4 clk = ~clk;

  bidir_byte_port i_bidir_byte_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .modeExt(modeExt), .extClkN(extClkN),
    .pinsIn(pinsIn), .pinsOut(pinsOut), .pinsOe(pinsOe)
  );

  function automatic logic [31:0] inMask(input logic [3:0] dir);
    return {{8{dir[3]}}, {8{dir[2]}}, {8{dir[1]}}, {8{dir[0]}}};
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] dir, input logic [31:0] outv,
                                          input logic [31:0] inv);
    return (inMask(dir) & inv) | (~inMask(dir) & outv);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [23:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [23:0] a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic setDir(input int k, input logic v);
    busWrite(24'h400000 + 24'(k) * 24'h040000, {31'h0, v});
    expDir[k] = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    expDir = 4'hF; expOut = '0; expLatch = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 oe", {28'h0, pinsOe}, 32'h0);
    check("R1 out", pinsOut, 32'h0);
    check("R1 rdata", busRdata, 32'h0);

    // R3 data write drives pinsOut regardless of direction
    busWrite(24'h300000, 32'hA5C3_0F12); expOut = 32'hA5C3_0F12;
    check("R3 out", pinsOut, expOut);

    // R2 lane directions one at a time
    setDir(1, 1'b0);
    check("R2 lane1", {28'h0, pinsOe}, {28'h0, ~expDir});
    setDir(3, 1'b0);
    check("R2 lane3", {28'h0, pinsOe}, {28'h0, ~expDir});
    setDir(1, 1'b1);
    check("R2 lane1 back", {28'h0, pinsOe}, {28'h0, ~expDir});

    // R4 / R5 directed read in software mode
    pinsIn = 32'h1122_3344;
    busRead(24'h300000, rd);
    check("R4 R5 read", rd, expRead(expDir, expOut, pinsIn));
    // R9 hold after pins change with no read
    pinsIn = 32'hFFFF_FFFF; idle(3);
    check("R9 hold", busRdata, expRead(expDir, expOut, 32'h1122_3344));

    // R8 unmapped write and read
    busWrite(24'h400004, 32'h0);
    busWrite(24'h300004, 32'hDEAD_BEEF);
    check("R8 oe", {28'h0, pinsOe}, {28'h0, ~expDir});
    check("R8 out", pinsOut, expOut);
    busRead(24'h123456, rd);
    check("R8 read zero", rd, 32'h0);

    // random mix in software mode (R2 R3 R4 R5)
    for (int i = 0; i < 60; i++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op == 0) setDir(int'($urandom_range(0, 3)), 1'($urandom));
      else if (op == 1) begin
        expOut = $urandom; busWrite(24'h300000, expOut);
      end
      pinsIn = $urandom;
      busRead(24'h300000, rd);
      check("R5 random read", rd, expRead(expDir, expOut, pinsIn));
      check("R2 random oe", {28'h0, pinsOe}, {28'h0, ~expDir});
      check("R3 random out", pinsOut, expOut);
    end

    // external mode: R6 and R7
    setDir(0, 1'b1); setDir(1, 1'b0); setDir(2, 1'b1); setDir(3, 1'b1);
    modeExt = 1'b1; idle(2);
    pinsIn = 32'hCAFE_BABE;
    extClkN = 1'b0; idle(5);
    expLatch = pinsIn;
    extClkN = 1'b1; idle(5);
    pinsIn = 32'h0000_0000;
    busRead(24'h300000, rd);
    check("R6 held capture", rd, expRead(expDir, expOut, expLatch));
    busRead(24'h300000, rd);
    check("R6 no recapture on read", rd, expRead(expDir, expOut, expLatch));

    // R7: rising edge must not capture
    extClkN = 1'b0; idle(5);
    expLatch = pinsIn;
    pinsIn = 32'h5A5A_5A5A;
    extClkN = 1'b1; idle(5);
    busRead(24'h300000, rd);
    check("R7 rising ignored", rd, expRead(expDir, expOut, expLatch));

    // R6 capture exactly on the third edge after the fall
    pinsIn = 32'h1357_9BDF;
    extClkN = 1'b0; idle(2);
    pinsIn = 32'h2468_ACE0;   // present before the third edge
    idle(1);
    expLatch = 32'h2468_ACE0;
    pinsIn = 32'h0F0F_0F0F;
    extClkN = 1'b1; idle(4);
    busRead(24'h300000, rd);
    check("R6 capture timing", rd, expRead(expDir, expOut, expLatch));

    // random external captures
    for (int i = 0; i < 20; i++) begin
      pinsIn = $urandom;
      extClkN = 1'b0; idle(4);
      expLatch = pinsIn;
      extClkN = 1'b1; pinsIn = $urandom; idle(4);
      busRead(24'h300000, rd);
      check("R6 random capture", rd, expRead(expDir, expOut, expLatch));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule